// File: doc/BRIEF.md
# Return Address Stack Predictor

This block supplies predicted targets for subroutine returns early in a fetch pipeline. A small direct-mapped tagged table classifies fetch addresses as calls, returns or swaps. It stores a two-bit kind instead of a target address. As a result, the stack of return addresses is pushed or popped in the same cycle the address is fetched, before any decode. On a call the block saves the call's fetch address plus 4. On a return it offers the most recent saved address as the next fetch address and discards it. On a swap, such as a coroutine hand-off, it does both.

The table is trained through an update port when a branch resolves. A separate check port compares a prediction carried down the pipeline with the resolved target and flags a mismatch. The stack is a circular buffer. When it is full, a new call overwrites the oldest entry. A return on an empty stack yields an invalid prediction.

Stack occupancy is tracked by a three-state controller. The states are `S_EMPTY`, `S_PARTIAL` and `S_FULL`. The transitions are:
- `T_FILL`: `S_EMPTY` to `S_PARTIAL` on a push.
- `T_TOP_OUT`: `S_PARTIAL` to `S_FULL` when a push reaches `DEPTH` entries.
- `T_DRAIN`: `S_PARTIAL` to `S_EMPTY` when a pop removes the last entry.
- `T_BACK_OFF`: `S_FULL` to `S_PARTIAL` on a pop.
- `T_WRAP`: `S_FULL` stays `S_FULL` on a push, which overwrites the oldest entry.

Top module: `ras_predictor`

## Requirements
- R1: After reset the stack is empty and every table entry is invalid, so no fetch address produces a push, a pop or a valid prediction.
- R2: A lookup hits only when `fetch_valid` is high and the indexed entry (index = `fetch_pc[IDX_W+1:2]`) is valid with all other PC bits equal to its tag. Kind code 0 is none, 1 is call, 2 is return and 3 is swap. `pred_push` is high for codes 1 and 3, and `pred_pop` is high for codes 2 and 3. A miss gives code 0.
- R3: A fetch that hits a call entry pushes `fetch_pc + 4`. A return fetched in the next cycle predicts exactly that value.
- R4: A fetch that hits a return entry on a non-empty stack drives `pred_valid` high and `pred_target` to the top entry, in the same cycle, and removes that entry at the clock edge.
- R5: Nested calls are returned in last-in, first-out order.
- R6: A push on a full stack of `DEPTH` entries overwrites the oldest entry. The next `DEPTH` returns give the newest `DEPTH` addresses, and the return after them is invalid.
- R7: A return on an empty stack gives `pred_valid` low and `pred_target` zero, and it leaves the stack empty.
- R8: A swap pops first and then pushes `fetch_pc + 4`. On a non-empty stack it predicts the old top and replaces it. On an empty stack it only pushes.
- R9: An update with `upd_valid` writes the kind for `upd_pc`. Code 0 invalidates the entry. The write is seen by lookups from the next cycle on, and a lookup in the same cycle sees the old contents.
- R10: `chk_miss` is high in the same cycle exactly when `chk_valid` is high and either `chk_pred_valid` is low or `chk_pred_target` differs from `chk_actual_target`.
- R11: While `fetch_valid` is low, no push or pop happens and the stack is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch address is presented this cycle |
| fetch_pc | input | PC_W | Fetch address |
| pred_push | output | 1 | Lookup classified the fetch as call or swap |
| pred_pop | output | 1 | Lookup classified the fetch as return or swap |
| pred_valid | output | 1 | Predicted return target is valid |
| pred_target | output | PC_W | Predicted return target, zero when invalid |
| upd_valid | input | 1 | Write the marker table this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_kind | input | 2 | Kind code for the resolved branch |
| chk_valid | input | 1 | A resolved return is being checked |
| chk_pred_valid | input | 1 | Whether a valid prediction was made for it |
| chk_pred_target | input | PC_W | Target that was predicted |
| chk_actual_target | input | PC_W | Target found at resolution |
| chk_miss | output | 1 | Prediction was wrong or missing |

## Verification
The properties assume one fetch lookup and at most one table write per cycle. They also assume that the update port and the fetch port see the same address width and alignment. The checks that follow an update or a push assume the following fetch is presented in the very next cycle. The stimulus keeps to these conditions. It drives all inputs only between clock edges from a single task. It programs the table through the update port alone, and it uses word-aligned addresses whose indices are chosen either to be distinct or to alias on purpose, which is how tag mismatch is exercised.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_CALL = 2'd1,
        KIND_RET  = 2'd2,
        KIND_SWAP = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        S_EMPTY   = 2'd0,
        S_PARTIAL = 2'd1,
        S_FULL    = 2'd2
    } occ_e;

endpackage

// File: rtl/ras_marker_table.sv
module ras_marker_table
    import ras_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_en,
    input  logic [PC_W-1:0] lk_pc,
    output kind_e           lk_kind,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  kind_e           wr_kind
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W;

    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    kind_e              kind_q [ENTRIES];

    logic [IDX_W-1:0] lk_idx, wr_idx;
    logic [TAG_W-1:0] lk_tag, wr_tag;

    // Index sits above the byte offset; tag is every other PC bit.
    assign lk_idx = lk_pc[IDX_W+1:2];
    assign wr_idx = wr_pc[IDX_W+1:2];
    assign lk_tag = {lk_pc[PC_W-1:IDX_W+2], lk_pc[1:0]};
    assign wr_tag = {wr_pc[PC_W-1:IDX_W+2], wr_pc[1:0]};

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[e]  <= 1'b0;
                tag_q[e]  <= '0;
                kind_q[e] <= KIND_NONE;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                vld_q[e]  <= (wr_kind != KIND_NONE);
                tag_q[e]  <= wr_tag;
                kind_q[e] <= wr_kind;
            end
        end
    end

    always_comb begin
        lk_kind = KIND_NONE;
        if (lk_en && vld_q[lk_idx] && tag_q[lk_idx] == lk_tag) begin
            lk_kind = kind_q[lk_idx];
        end
    end

endmodule

// File: rtl/ras_occupancy_ctrl.sv
module ras_occupancy_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  kind_e kind,
    output logic  push_req,
    output logic  pop_req,
    output logic  do_push,
    output logic  do_pop,
    output logic  pred_valid
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    occ_e             state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        push_req = (kind == KIND_CALL) || (kind == KIND_SWAP);
        pop_req  = (kind == KIND_RET)  || (kind == KIND_SWAP);
    end

    // Next occupancy and state.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_EMPTY: begin
                if (push_req) begin              // T_FILL
                    cnt_d   = CNT_W'(1);
                    state_d = (CNT_MAX == CNT_W'(1)) ? S_FULL : S_PARTIAL;
                end
            end
            S_PARTIAL: begin
                if (push_req && !pop_req) begin
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_d == CNT_MAX) state_d = S_FULL;       // T_TOP_OUT
                end else if (pop_req && !push_req) begin
                    cnt_d = cnt_q - CNT_W'(1);
                    if (cnt_d == '0) state_d = S_EMPTY;           // T_DRAIN
                end
            end
            S_FULL: begin
                if (pop_req && !push_req) begin                   // T_BACK_OFF
                    cnt_d   = cnt_q - CNT_W'(1);
                    state_d = (cnt_d == '0) ? S_EMPTY : S_PARTIAL;
                end
                // push alone: T_WRAP, count stays at DEPTH
            end
            default: begin
                state_d = S_EMPTY;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Actions handed to the storage.
    always_comb begin
        do_push    = 1'b0;
        do_pop     = 1'b0;
        pred_valid = 1'b0;
        unique case (state_q)
            S_EMPTY: begin
                do_push = push_req;
            end
            S_PARTIAL, S_FULL: begin
                do_push    = push_req;
                do_pop     = pop_req;
                pred_valid = pop_req;
            end
            default: begin
                do_push = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ras_ring_stack.sv
module ras_ring_stack #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            do_push,
    input  logic            do_pop,
    input  logic [PC_W-1:0] push_data,
    output logic [PC_W-1:0] top_data
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PC_W-1:0]  mem_q [DEPTH];
    logic [PTR_W-1:0] wptr_q, top_idx, wptr_inc;

    // wptr points at the slot the next push fills; the oldest entry when full.
    assign top_idx  = (wptr_q == '0)   ? LAST : wptr_q - PTR_W'(1);
    assign wptr_inc = (wptr_q == LAST) ? '0   : wptr_q + PTR_W'(1);
    assign top_data = mem_q[top_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
        end else if (do_push && !do_pop) begin
            wptr_q <= wptr_inc;
        end else if (do_pop && !do_push) begin
            wptr_q <= top_idx;
        end
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[s] <= '0;
            end else if (do_push && do_pop && top_idx == PTR_W'(s)) begin
                mem_q[s] <= push_data;          // pop then push: replace top
            end else if (do_push && !do_pop && wptr_q == PTR_W'(s)) begin
                mem_q[s] <= push_data;
            end
        end
    end

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
    import ras_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int DEPTH       = 8,
    parameter int TBL_ENTRIES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_valid,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_push,
    output logic            pred_pop,
    output logic            pred_valid,
    output logic [PC_W-1:0] pred_target,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [1:0]      upd_kind,
    input  logic            chk_valid,
    input  logic            chk_pred_valid,
    input  logic [PC_W-1:0] chk_pred_target,
    input  logic [PC_W-1:0] chk_actual_target,
    output logic            chk_miss
);
    kind_e           lk_kind;
    logic            do_push, do_pop, valid_int;
    logic [PC_W-1:0] top_data, ret_addr;

    assign ret_addr = fetch_pc + PC_W'(4);

    ras_marker_table #(.PC_W(PC_W), .ENTRIES(TBL_ENTRIES)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_en   (fetch_valid),
        .lk_pc   (fetch_pc),
        .lk_kind (lk_kind),
        .wr_en   (upd_valid),
        .wr_pc   (upd_pc),
        .wr_kind (kind_e'(upd_kind))
    );

    ras_occupancy_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (lk_kind),
        .push_req   (pred_push),
        .pop_req    (pred_pop),
        .do_push    (do_push),
        .do_pop     (do_pop),
        .pred_valid (valid_int)
    );

    ras_ring_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_push   (do_push),
        .do_pop    (do_pop),
        .push_data (ret_addr),
        .top_data  (top_data)
    );

    assign pred_valid  = valid_int;
    assign pred_target = valid_int ? top_data : '0;
    assign chk_miss    = chk_valid &&
                         (!chk_pred_valid || chk_pred_target != chk_actual_target);

endmodule

// File: rtl/ras_predictor_checker.sv
module ras_predictor_checker
    import ras_pkg::*;
#(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fetch_valid,
    input logic [PC_W-1:0] fetch_pc,
    input logic            pred_push,
    input logic            pred_pop,
    input logic            pred_valid,
    input logic [PC_W-1:0] pred_target,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic [1:0]      upd_kind,
    input logic            chk_valid,
    input logic            chk_pred_valid,
    input logic [PC_W-1:0] chk_pred_target,
    input logic [PC_W-1:0] chk_actual_target,
    input logic            chk_miss
);
    p_idle_fetch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> !pred_push && !pred_pop);

    p_valid_needs_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> pred_pop);

    p_invalid_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |-> pred_target == '0);

    p_push_then_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_push ##1 pred_pop |-> pred_valid && pred_target == $past(fetch_pc) + PC_W'(4));

    p_update_seen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_kind == 2'(KIND_CALL)) ##1 (fetch_valid && fetch_pc == $past(upd_pc))
        |-> pred_push && !pred_pop);

    p_check_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_pred_valid && chk_pred_target == chk_actual_target) |-> !chk_miss);

    p_check_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> !chk_miss);
endmodule

bind ras_predictor ras_predictor_checker #(.PC_W(PC_W)) u_checker (.*);

// File: tb/ras_predictor_bench.sv
module ras_predictor_bench;
    localparam int PC_W  = 32;
    localparam int DEPTH = 8;
    localparam int IDX_W = 4;
    localparam logic [31:0] IDX_MASK = 32'h0000_003C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_push, pred_pop, pred_valid, chk_miss;
    logic [31:0] pred_target;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic [1:0]  upd_kind = '0;
    logic        chk_valid = 1'b0, chk_pred_valid = 1'b0;
    logic [31:0] chk_pred_target = '0, chk_actual_target = '0;

    int vectors = 0;
    int errors  = 0;

    // Behavioural model
    logic [31:0] stk [$];
    logic [31:0] tbl_pc   [int];
    logic [1:0]  tbl_kind [int];

    always #2 clk = ~clk;

    ras_predictor #(.PC_W(PC_W), .DEPTH(DEPTH), .TBL_ENTRIES(1 << IDX_W)) u_ras_predictor (.*);

    function automatic logic [1:0] model_kind();
        int idx = int'((fetch_pc >> 2) & 32'hF);
        if (!fetch_valid || !tbl_pc.exists(idx)) return 2'd0;
        if (((tbl_pc[idx] ^ fetch_pc) & ~IDX_MASK) != 0) return 2'd0;
        return tbl_kind[idx];
    endfunction

    task automatic cyc(input string req);
        logic [1:0]  k;
        logic        e_push, e_pop, e_pv, e_miss;
        logic [31:0] e_tgt;
        #1;
        k      = model_kind();
        e_push = (k == 2'd1) || (k == 2'd3);
        e_pop  = (k == 2'd2) || (k == 2'd3);
        e_pv   = e_pop && stk.size() > 0;
        e_tgt  = e_pv ? stk[$] : 32'h0;
        e_miss = chk_valid && (!chk_pred_valid || chk_pred_target != chk_actual_target);
        vectors++;
        if (pred_push !== e_push || pred_pop !== e_pop || pred_valid !== e_pv ||
            pred_target !== e_tgt || chk_miss !== e_miss) begin
            errors++;
            $display("FAIL %s: got push=%b pop=%b valid=%b target=%h miss=%b, expected push=%b pop=%b valid=%b target=%h miss=%b",
                     req, pred_push, pred_pop, pred_valid, pred_target, chk_miss,
                     e_push, e_pop, e_pv, e_tgt, e_miss);
        end
        @(posedge clk);
        if (e_pop && stk.size() > 0) void'(stk.pop_back());
        if (e_push) begin
            stk.push_back(fetch_pc + 32'd4);
            if (stk.size() > DEPTH) void'(stk.pop_front());
        end
        if (upd_valid) begin
            int idx = int'((upd_pc >> 2) & 32'hF);
            if (upd_kind == 2'd0) begin
                tbl_pc.delete(idx);
                tbl_kind.delete(idx);
            end else begin
                tbl_pc[idx]   = upd_pc;
                tbl_kind[idx] = upd_kind;
            end
        end
        @(negedge clk);
    endtask

    task automatic fetch(input logic [31:0] pc, input string req);
        fetch_valid = 1'b1; fetch_pc = pc;
        cyc(req);
        fetch_valid = 1'b0;
    endtask

    task automatic train(input logic [31:0] pc, input logic [1:0] k, input string req);
        upd_valid = 1'b1; upd_pc = pc; upd_kind = k;
        cyc(req);
        upd_valid = 1'b0;
    endtask

    localparam logic [31:0] PC_A   = 32'h0000_1004;  // call, idx 1
    localparam logic [31:0] PC_RET = 32'h0000_2008;  // return, idx 2
    localparam logic [31:0] PC_SWP = 32'h0000_300C;  // swap, idx 3
    localparam logic [31:0] PC_ALS = 32'h0000_5004;  // aliases idx 1

    function automatic logic [31:0] call_pc(input int k);
        return 32'h0001_0000 + 32'(4 * k);
    endfunction

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: got no completion, expected end of run");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: nothing is predicted after reset
        fetch(PC_A, "R1");
        fetch(PC_RET, "R1");
        // R9: program the table; a lookup in the write cycle sees the old contents
        upd_valid = 1'b1; upd_pc = PC_A; upd_kind = 2'd1;
        fetch_valid = 1'b1; fetch_pc = PC_A;
        cyc("R9");
        fetch_valid = 1'b0; upd_valid = 1'b0;
        train(PC_RET, 2'd2, "R9");
        train(PC_SWP, 2'd3, "R9");
        for (int k = 4; k <= 12; k++) train(call_pc(k), 2'd1, "R9");
        // R2: alias with a different tag misses; R11: fetch_valid low does nothing
        fetch(PC_ALS, "R2");
        fetch_valid = 1'b0; fetch_pc = PC_A; cyc("R11");
        // R3, R4, R5: nested calls return in reverse order
        fetch(call_pc(4), "R3");
        fetch(call_pc(5), "R3");
        fetch(call_pc(6), "R3");
        fetch(PC_RET, "R4");
        fetch(PC_RET, "R5");
        fetch(PC_RET, "R5");
        // R7: empty pop
        fetch(PC_RET, "R7");
        fetch(PC_RET, "R7");
        // R6: overflow by one then drain past empty
        for (int k = 4; k <= 12; k++) fetch(call_pc(k), "R6");
        for (int k = 0; k < DEPTH + 1; k++) fetch(PC_RET, "R6");
        // R8: swap on non-empty and on empty stack
        fetch(call_pc(4), "R8");
        fetch(PC_SWP, "R8");
        fetch(PC_RET, "R8");
        fetch(PC_RET, "R8");
        fetch(PC_SWP, "R8");
        fetch(PC_RET, "R8");
        // R9: invalidate then lookup
        train(PC_A, 2'd0, "R9");
        fetch(PC_A, "R9");
        // R10: check port patterns
        chk_valid = 1'b1; chk_pred_valid = 1'b1;
        chk_pred_target = 32'h40; chk_actual_target = 32'h40; cyc("R10");
        chk_actual_target = 32'h44; cyc("R10");
        chk_pred_valid = 1'b0; chk_actual_target = 32'h40; cyc("R10");
        chk_valid = 1'b0; chk_pred_valid = 1'b1; chk_actual_target = 32'h48; cyc("R10");
        // Mixed traffic, compared every clock
        for (int n = 0; n < 600; n++) begin
            int sel = int'($urandom_range(0, 11));
            fetch_valid = ($urandom_range(0, 4) != 0);
            case (sel)
                0, 1, 2: fetch_pc = PC_RET;
                3:       fetch_pc = PC_SWP;
                4:       fetch_pc = PC_ALS;
                5:       fetch_pc = PC_A;
                default: fetch_pc = call_pc(int'($urandom_range(4, 12)));
            endcase
            upd_valid = ($urandom_range(0, 9) == 0);
            upd_pc    = ($urandom_range(0, 1) != 0) ? PC_A : PC_ALS;
            upd_kind  = 2'($urandom_range(0, 3));
            chk_valid = $urandom_range(0, 1) != 0;
            chk_pred_valid = $urandom_range(0, 1) != 0;
            chk_pred_target = 32'($urandom_range(0, 3));
            chk_actual_target = 32'($urandom_range(0, 3));
            cyc("R2 R4 R8 R10 mixed");
        end
        fetch_valid = 1'b0; upd_valid = 1'b0; chk_valid = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule